// File: doc/BRIEF.md
# Cache-Block Zeroing Engine

This engine performs the memory side of a block-clear operation after the upstream permission logic has finished its checks. A requester presents a byte address together with two verdicts from upstream: whether zeroing is allowed, and whether a store-type access probe of the address succeeded. If both verdicts are good, the engine rounds the address down to the start of its enclosing block. It then streams zero words, with all byte strobes set, to a single memory write port that uses a valid/ready handshake. It does this until every byte of the block has been cleared.

The byte offset inside the block never matters: a request anywhere in a block clears that whole block. Block size, word size and address width are parameters. If a verdict is bad, the engine reports the rejection with a one-cycle pulse and issues no write. A refused permission is reported separately from a failed probe.

Top module: `blkzero_engine`

## Requirements
- R1: The first write of a burst goes to the request address with its low log2(BLK_BYTES) bits cleared, for every byte offset of the request.
- R2: A burst is exactly BLK_BYTES/WORD_BYTES beats. Beat n has address base + n*WORD_BYTES, and no write follows the last beat.
- R3: Every beat carries all-zero data with every byte strobe bit set to 1.
- R4: A beat completes only in a cycle where `wr_valid` and `wr_ready` are both high. While `wr_ready` is low, `wr_valid`, `wr_addr` and `wr_data` hold their values.
- R5: `busy` is high from the cycle after an accepted request through the cycle of the final handshake. `done` is high for exactly the one cycle after the final handshake, and `busy` is low in that cycle.
- R6: A request presented while `busy` is high is ignored. The burst in progress keeps its addresses, and no extra burst follows it.
- R7: A request with `perm_ok` low produces a one-cycle `deny` pulse in the next cycle and no write. It leaves `busy` low, and it takes priority over a failed probe, so `fault` stays low.
- R8: A request with `perm_ok` high and `probe_ok` low produces a one-cycle `fault` pulse in the next cycle and no write. It leaves `busy` low.
- R9: Synchronous reset, including in the middle of a burst, returns the engine to idle in the next cycle. After that edge `wr_valid`, `busy`, `done`, `deny` and `fault` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_valid | input | 1 | Request strobe, taken only while idle |
| start_addr | input | ADDR_W | Byte address of the request |
| perm_ok | input | 1 | Upstream verdict: zeroing allowed |
| probe_ok | input | 1 | Upstream verdict: store probe succeeded |
| wr_valid | output | 1 | Write beat offered |
| wr_ready | input | 1 | Memory accepts the offered beat |
| wr_addr | output | ADDR_W | Byte address of the beat |
| wr_data | output | WORD_BYTES*8 | Beat data (zero) |
| wr_strb | output | WORD_BYTES | Byte strobes |
| busy | output | 1 | Burst in progress |
| done | output | 1 | One-cycle pulse after the final beat |
| deny | output | 1 | One-cycle pulse: request refused by permission |
| fault | output | 1 | One-cycle pulse: request aborted by failed probe |

## Verification
The assertions assume that the memory side may hold `wr_ready` low for any number of cycles, and that `start_addr` is meaningful only in the cycle a request is taken. They also assume the two verdicts are valid in that same cycle, so the first-beat check compares against the address sampled on the previous edge. The stimulus changes inputs only between clock edges. It takes every byte offset of a block under four ready patterns, including long stalls, and pokes conflicting requests only while a burst is running. It covers every combination of the verdicts, and it applies reset only in the middle of a burst or while idle.

// File: rtl/blkz_pkg.sv
package blkz_pkg;

   typedef enum logic [0:0] {
      BZ_IDLE  = 1'b0,
      BZ_WRITE = 1'b1
   } bz_state_e;

   function automatic bit blkz_is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/blkz_align.sv
module blkz_align #(
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned BLK_BYTES = 64
) (
   input  logic [ADDR_W-1:0] byte_addr,
   output logic [ADDR_W-1:0] blk_base
);
   localparam logic [ADDR_W-1:0] OFS_MASK = ADDR_W'(BLK_BYTES - 1);

   // Clear the in-block offset bits; block size is a power of two.
   assign blk_base = byte_addr & ~OFS_MASK;
endmodule

// File: rtl/blkz_beat_seq.sv
module blkz_beat_seq #(
   parameter int unsigned BEATS = 16,
   localparam int unsigned BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic              advance,
   output logic [BEAT_W-1:0] idx,
   output logic              last
);
   logic [BEAT_W-1:0] idx_q;

   assign idx  = idx_q;
   assign last = (idx_q == BEAT_W'(BEATS - 1));

   always_ff @(posedge clk) begin
      if (rst) begin
         idx_q <= '0;
      end else if (load) begin
         idx_q <= '0;
      end else if (advance) begin
         idx_q <= last ? '0 : idx_q + 1'b1;
      end
   end

   // After the final beat the counter is back at zero for the next burst (R2).
   assert_wrap_R2 : assert property (@(posedge clk) disable iff (rst)
      (advance && last && !load) |=> (idx_q == '0));

   // Index never exceeds the beat count (R2).
   assert_range_R2 : assert property (@(posedge clk) disable iff (rst)
      (32'(idx_q) < BEATS));
endmodule

// File: rtl/blkzero_engine.sv
module blkzero_engine
   import blkz_pkg::*;
#(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned BLK_BYTES  = 64,
   parameter int unsigned WORD_BYTES = 4
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    start_valid,
   input  logic [ADDR_W-1:0]       start_addr,
   input  logic                    perm_ok,
   input  logic                    probe_ok,
   output logic                    wr_valid,
   input  logic                    wr_ready,
   output logic [ADDR_W-1:0]       wr_addr,
   output logic [WORD_BYTES*8-1:0] wr_data,
   output logic [WORD_BYTES-1:0]   wr_strb,
   output logic                    busy,
   output logic                    done,
   output logic                    deny,
   output logic                    fault
);
   localparam int unsigned OFS_W  = $clog2(BLK_BYTES);
   localparam int unsigned WB_W   = $clog2(WORD_BYTES);
   localparam int unsigned BEATS  = BLK_BYTES / WORD_BYTES;
   localparam int unsigned BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1;

   // Elaboration-time parameter checks.
   if (!blkz_is_pow2(BLK_BYTES)) begin : g_chk_blk
      $error("blkzero_engine: BLK_BYTES must be a power of two");
   end
   if (!blkz_is_pow2(WORD_BYTES)) begin : g_chk_word
      $error("blkzero_engine: WORD_BYTES must be a power of two");
   end
   if (BLK_BYTES < WORD_BYTES) begin : g_chk_ratio
      $error("blkzero_engine: BLK_BYTES must not be below WORD_BYTES");
   end
   if (ADDR_W <= OFS_W) begin : g_chk_aw
      $error("blkzero_engine: ADDR_W too narrow for BLK_BYTES");
   end

   bz_state_e         state_q;
   logic [ADDR_W-1:0] base_q;
   logic [ADDR_W-1:0] aligned;
   logic [BEAT_W-1:0] beat_idx;
   logic              beat_last;
   logic              done_q, deny_q, fault_q;
   logic              take, go, fire;

   blkz_align #(
      .ADDR_W   (ADDR_W),
      .BLK_BYTES(BLK_BYTES)
   ) u_align (
      .byte_addr(start_addr),
      .blk_base (aligned)
   );

   assign take = start_valid && (state_q == BZ_IDLE);
   assign go   = take && perm_ok && probe_ok;
   assign fire = wr_valid && wr_ready;

   blkz_beat_seq #(
      .BEATS(BEATS)
   ) u_beats (
      .clk    (clk),
      .rst    (rst),
      .load   (go),
      .advance(fire),
      .idx    (beat_idx),
      .last   (beat_last)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= BZ_IDLE;
         base_q  <= '0;
         done_q  <= 1'b0;
         deny_q  <= 1'b0;
         fault_q <= 1'b0;
      end else begin
         done_q  <= fire && beat_last;
         deny_q  <= take && !perm_ok;
         fault_q <= take && perm_ok && !probe_ok;
         unique case (state_q)
            BZ_IDLE: begin
               if (go) begin
                  state_q <= BZ_WRITE;
                  base_q  <= aligned;
               end
            end
            BZ_WRITE: begin
               if (fire && beat_last) begin
                  state_q <= BZ_IDLE;
               end
            end
            default: state_q <= BZ_IDLE;
         endcase
      end
   end

   assign wr_valid = (state_q == BZ_WRITE);
   assign busy     = (state_q == BZ_WRITE);
   assign wr_addr  = base_q | (ADDR_W'(beat_idx) << WB_W);
   assign wr_data  = '0;
   assign wr_strb  = '1;
   assign done     = done_q;
   assign deny     = deny_q;
   assign fault    = fault_q;

   // First beat lands on the block boundary of the taken address (R1).
   assert_first_beat_R1 : assert property (@(posedge clk) disable iff (rst)
      $rose(wr_valid) |-> (wr_addr == (($past(start_addr) >> OFS_W) << OFS_W)));

   // Accepted beats step by one word (R2).
   assert_step_R2 : assert property (@(posedge clk) disable iff (rst)
      fire |=> (!wr_valid || (wr_addr == $past(wr_addr) + ADDR_W'(WORD_BYTES))));

   // Offered beat holds while the sink stalls (R4).
   assert_hold_R4 : assert property (@(posedge clk) disable iff (rst)
      (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

   // Done follows a handshake and is never seen with busy (R5).
   assert_done_R5 : assert property (@(posedge clk) disable iff (rst)
      done |-> ($past(fire) && !busy));

   // Done lasts one cycle (R5).
   assert_done_pulse_R5 : assert property (@(posedge clk) disable iff (rst)
      done |=> !done);

   // A busy engine without a handshake stays on the same beat, whatever start does (R6).
   assert_ignore_R6 : assert property (@(posedge clk) disable iff (rst)
      (busy && !fire) |=> (busy && $stable(wr_addr)));

   // Deny only after an idle request, never with a write or a fault (R7).
   assert_deny_R7 : assert property (@(posedge clk) disable iff (rst)
      deny |-> (!fault && !wr_valid && $past(start_valid && !busy && !perm_ok)));

   // Fault only after a permitted idle request, with no write (R8).
   assert_fault_R8 : assert property (@(posedge clk) disable iff (rst)
      fault |-> (!wr_valid && $past(start_valid && !busy && perm_ok && !probe_ok)));

   // Reset leaves nothing outstanding (R9).
   assert_reset_R9 : assert property (@(posedge clk)
      $past(rst) |-> (!wr_valid && !busy && !done && !deny && !fault));
endmodule

// File: tb/blkzero_engine_bench.sv
module blkzero_engine_bench;
   localparam int AW    = 32;
   localparam int BLK   = 64;
   localparam int WB    = 4;
   localparam int BEATS = BLK / WB;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          start_valid = 1'b0;
   logic [AW-1:0] start_addr = '0;
   logic          perm_ok = 1'b0;
   logic          probe_ok = 1'b0;
   logic          wr_valid;
   logic          wr_ready = 1'b0;
   logic [AW-1:0] wr_addr;
   logic [WB*8-1:0] wr_data;
   logic [WB-1:0] wr_strb;
   logic          busy, done, deny, fault;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   blkzero_engine #(
      .ADDR_W    (AW),
      .BLK_BYTES (BLK),
      .WORD_BYTES(WB)
   ) u_blkzero_engine (
      .clk        (clk),
      .rst        (rst),
      .start_valid(start_valid),
      .start_addr (start_addr),
      .perm_ok    (perm_ok),
      .probe_ok   (probe_ok),
      .wr_valid   (wr_valid),
      .wr_ready   (wr_ready),
      .wr_addr    (wr_addr),
      .wr_data    (wr_data),
      .wr_strb    (wr_strb),
      .busy       (busy),
      .done       (done),
      .deny       (deny),
      .fault      (fault)
   );

   task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                      input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic bit rdy_pat(input int p, input int c);
      case (p)
         0:       return 1'b1;
         1:       return c[0];
         2:       return ((c * 7 + 3) % 5) != 0;
         default: return (c % 4) == 3;
      endcase
   endfunction

   task automatic idle_outputs(input string tag);
      chk(!wr_valid, {tag, " wr_valid"}, 64'(wr_valid), 0);
      chk(!busy,     {tag, " busy"},     64'(busy),     0);
      chk(!done,     {tag, " done"},     64'(done),     0);
      chk(!deny,     {tag, " deny"},     64'(deny),     0);
      chk(!fault,    {tag, " fault"},    64'(fault),    0);
   endtask

   task automatic run_burst(input logic [AW-1:0] addr, input int p, input bit poke);
      logic [AW-1:0] exp_base;
      logic [AW-1:0] prev_addr;
      logic [AW-1:0] exp_a;
      bit            prev_rdy;
      int            idx;
      int            c;
      exp_base = (addr / BLK) * BLK;
      @(negedge clk);
      start_valid = 1'b1; start_addr = addr; perm_ok = 1'b1; probe_ok = 1'b1;
      @(negedge clk);
      start_valid = 1'b0;
      chk(busy, "R5 busy after start", 64'(busy), 1);
      idx = 0; c = 0; prev_rdy = 1'b1; prev_addr = '0;
      while (idx < BEATS && c < 400) begin
         wr_ready = rdy_pat(p, c);
         if (poke) begin
            start_valid = 1'b1;
            start_addr  = addr ^ 32'hFFFF_0040;
         end
         exp_a = exp_base + AW'(idx * WB);
         chk(wr_valid, "R2 valid during burst", 64'(wr_valid), 1);
         if (idx == 0)
            chk(wr_addr == exp_a, "R1 first beat address", 64'(wr_addr), 64'(exp_a));
         else
            chk(wr_addr == exp_a, poke ? "R6 beat address under poke" : "R2 beat address",
                64'(wr_addr), 64'(exp_a));
         if (c > 0 && !prev_rdy)
            chk(wr_addr == prev_addr, "R4 hold while stalled", 64'(wr_addr), 64'(prev_addr));
         chk(wr_data == '0 && wr_strb == '1, "R3 zero data full strobes",
             64'({wr_strb, wr_data}), 64'({{WB{1'b1}}, {WB*8{1'b0}}}));
         chk(busy && !done, "R5 busy no done mid burst", 64'({busy, done}), 64'(2));
         prev_rdy  = wr_ready;
         prev_addr = wr_addr;
         if (wr_ready) idx++;
         c++;
         @(negedge clk);
      end
      start_valid = 1'b0;
      wr_ready    = 1'b0;
      chk(done, "R5 done after last beat", 64'(done), 1);
      chk(!busy, "R5 busy low with done", 64'(busy), 0);
      chk(!wr_valid, "R2 no extra beat", 64'(wr_valid), 0);
      @(negedge clk);
      chk(!done, "R5 done one cycle", 64'(done), 0);
      if (poke) chk(!wr_valid && !busy, "R6 no burst from ignored start",
                    64'({wr_valid, busy}), 0);
   endtask

   task automatic run_reject(input logic [AW-1:0] addr, input bit perm, input bit probe);
      bit exp_deny;
      bit exp_fault;
      exp_deny  = !perm;
      exp_fault = perm && !probe;
      @(negedge clk);
      start_valid = 1'b1; start_addr = addr; perm_ok = perm; probe_ok = probe;
      @(negedge clk);
      start_valid = 1'b0; wr_ready = 1'b1;
      chk(deny == exp_deny, "R7 deny pulse", 64'(deny), 64'(exp_deny));
      chk(fault == exp_fault, exp_deny ? "R7 deny over fault" : "R8 fault pulse",
          64'(fault), 64'(exp_fault));
      chk(!wr_valid && !busy, exp_deny ? "R7 no write" : "R8 no write",
          64'({wr_valid, busy}), 0);
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         chk(!wr_valid && !deny && !fault, exp_deny ? "R7 quiet after" : "R8 quiet after",
             64'({wr_valid, deny, fault}), 0);
      end
      wr_ready = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog actual expired expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      idle_outputs("R9 reset state");
      rst = 1'b0;
      @(negedge clk);
      idle_outputs("R9 idle after reset");

      for (int p = 0; p < 4; p++) begin
         for (int k = 0; k < 64; k++) begin
            run_burst(32'h1234_5000 + AW'(k) * 32'h0000_1041, p, (p == 3) && (k % 4 == 0));
         end
      end

      run_reject(32'h0000_0a7c, 1'b0, 1'b1);
      run_reject(32'h0000_0a7c, 1'b1, 1'b0);
      run_reject(32'hfff0_0013, 1'b0, 1'b0);
      run_burst(32'hfff0_0013, 1, 1'b0);

      // Reset in the middle of a burst (R9).
      @(negedge clk);
      start_valid = 1'b1; start_addr = 32'h0000_2222; perm_ok = 1'b1; probe_ok = 1'b1;
      @(negedge clk);
      start_valid = 1'b0; wr_ready = 1'b1;
      repeat (3) @(negedge clk);
      chk(busy, "R9 burst running before reset", 64'(busy), 1);
      rst = 1'b1;
      @(negedge clk);
      idle_outputs("R9 reset mid burst");
      rst = 1'b0;
      repeat (2) @(negedge clk);
      idle_outputs("R9 stays idle");
      wr_ready = 1'b0;
      run_burst(32'h0000_2222, 2, 1'b0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule